// File: doc/BRIEF.md
# Configurable Logic Cell

This block models one basic logic element of a programmable fabric. A 4-input look-up table turns the four data inputs into one output bit by selecting one bit of a stored 16-bit truth table. A D flip-flop can capture that bit. An output multiplexer then presents either the table output or the registered value. Because the whole truth table is stored, any function of the four inputs can be built.

The flip-flop's behaviour is set by configuration. Configuration chooses the clock edge (rising or falling), whether set/reset acts synchronously or asynchronously, the value that set/reset forces, and whether the output is combinational or registered. The configuration is 20 bits long. It enters one bit per rising clock edge through a serial loader, and only while the load-enable input is high. While loading is in progress the cell output stays at 0 and the flip-flop keeps its value.

A system reset (`rst_ni`, active low) takes effect at once and is released in step with the clock. It clears the configuration and the flip-flop.

Top module: `cfg_logic_cell`

## Requirements
- R1: After system reset the configuration is all zero (combinational output, table all 0) and `cell_o` reads 0.
- R2: In combinational mode (output select = 0) `cell_o` equals truth-table bit k, where k = `din_i` read as a binary number with `din_i[0]` as its least significant bit. The value follows `din_i` in the same cycle.
- R3: On each rising edge with `cfg_en_i` high, `cfg_bit_i` enters the configuration from the top and all stored bits move one place down. After 20 such edges the first bit sent sits at position 0. Positions 0..15 hold the truth table, 16 is clock invert, 17 is reset mode (1 = asynchronous), 18 is the set/reset value, and 19 is output select (1 = registered).
- R4: While `cfg_en_i` is high, `cell_o` is 0 and the flip-flop keeps its value; `ce_i` and `sr_i` have no effect.
- R5: In registered mode with `ce_i` high and `sr_i` low, the flip-flop captures the table output on the active clock edge. `cell_o` shows the captured value after that edge.
- R6: With `ce_i` low and `sr_i` low, the flip-flop keeps its value across active edges.
- R7: In synchronous reset mode, `sr_i` high loads the configured set/reset value at the next active edge and does not change the flip-flop before that edge.
- R8: In asynchronous reset mode, `sr_i` high forces the configured set/reset value at once, without waiting for a clock edge.
- R9: Set/reset takes priority over `ce_i` in both reset modes.
- R10: With clock invert = 1 the flip-flop samples on the falling clock edge instead of the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | System reset, active low; applied at once, released in step with the clock |
| cfg_en_i | input | 1 | Configuration load enable |
| cfg_bit_i | input | 1 | Serial configuration data |
| din_i | input | 4 | Look-up table inputs; bit 0 is the least significant index bit |
| ce_i | input | 1 | Flip-flop clock enable, active high |
| sr_i | input | 1 | Flip-flop set/reset, active high |
| cell_o | output | 1 | Cell output (table output or flip-flop output) |

## Verification
The configuration register sets every later response of the cell, so a wrong bit in it shows up quickly at `cell_o`. A wrong table bit appears in the same cycle as soon as `din_i` selects that entry in combinational mode. A wrong mode bit shows either one edge early or late (synchronous against asynchronous reset), or half a cycle off (clock polarity). A stuck or mis-enabled flip-flop shows at `cell_o` on the first active edge after the stimulus, in registered mode. The checks therefore sample `cell_o` in the stimulus cycle and in the cycle after it. One case changes `din_i` between the falling and rising edges, so that the two clock polarities give different results.

// File: rtl/cell_pkg.sv
package cell_pkg;
  // Mode bits above the truth table, highest first (packed order matches load order)
  typedef struct packed {
    logic reg_out;   // 1: output the flip-flop
    logic rval;      // value forced by set/reset
    logic async_m;   // 1: set/reset acts without a clock edge
    logic inv;       // 1: sample on falling edge
  } cell_ctl_t;

  localparam int CTL_W = $bits(cell_ctl_t);

  function automatic int tbl_width(input int k);
    return 1 << k;
  endfunction
endpackage

// File: rtl/cell_rst_sync.sv
module cell_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_no = stage_q[1];
endmodule

// File: rtl/cell_cfg_shift.sv
module cell_cfg_shift #(
  parameter int W = 20
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] vec_o
);
  logic [W-1:0] vec_q, vec_d;

  always_comb begin
    vec_d = vec_q;
    if (en_i) vec_d = {bit_i, vec_q[W-1:1]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vec_q <= '0;
    else         vec_q <= vec_d;
  end

  assign vec_o = vec_q;
endmodule

// File: rtl/cell_lut.sv
module cell_lut #(
  parameter int K = 4,
  localparam int TBL_W = 1 << K
) (
  input  logic [TBL_W-1:0] tbl_i,
  input  logic [K-1:0]     idx_i,
  output logic             y_o
);
  // Heap-ordered mux tree: node 1 is the root, leaves sit at TBL_W..2*TBL_W-1
  logic [2*TBL_W-1:1] node;

  assign node[2*TBL_W-1:TBL_W] = tbl_i;

  for (genvar d = 0; d < K; d++) begin : g_lvl
    for (genvar j = 0; j < (1 << d); j++) begin : g_node
      localparam int N = (1 << d) + j;
      assign node[N] = idx_i[K-1-d] ? node[2*N+1] : node[2*N];
    end
  end

  assign y_o = node[1];
endmodule

// File: rtl/cell_store.sv
module cell_store (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic d_i,
  input  logic ce_i,
  input  logic sr_i,
  input  logic async_m_i,
  input  logic rval_i,
  input  logic inv_i,
  output logic q_o
);
  logic q_rise_q, q_fall_q;
  logic nxt_rise, nxt_fall;
  logic sync_sr, arst, cap;

  assign sync_sr = sr_i & ~async_m_i & ~hold_i;
  assign arst    = sr_i &  async_m_i & ~hold_i;
  assign cap     = ce_i & ~hold_i;

  always_comb begin
    nxt_rise = q_rise_q;
    if (sync_sr)  nxt_rise = rval_i;
    else if (cap) nxt_rise = d_i;
  end

  always_comb begin
    nxt_fall = q_fall_q;
    if (sync_sr)  nxt_fall = rval_i;
    else if (cap) nxt_fall = d_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni or posedge arst) begin
    if (!rst_ni)   q_rise_q <= 1'b0;
    else if (arst) q_rise_q <= rval_i;
    else           q_rise_q <= nxt_rise;
  end

  always_ff @(negedge clk_i or negedge rst_ni or posedge arst) begin
    if (!rst_ni)   q_fall_q <= 1'b0;
    else if (arst) q_fall_q <= rval_i;
    else           q_fall_q <= nxt_fall;
  end

  assign q_o = inv_i ? q_fall_q : q_rise_q;
endmodule

// File: rtl/cfg_logic_cell.sv
module cfg_logic_cell
  import cell_pkg::*;
#(
  parameter int K = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cfg_en_i,
  input  logic         cfg_bit_i,
  input  logic [K-1:0] din_i,
  input  logic         ce_i,
  input  logic         sr_i,
  output logic         cell_o
);
  localparam int TBL_W = 1 << K;
  localparam int CFG_W = TBL_W + CTL_W;

  logic             rst_n_q;
  logic [CFG_W-1:0] cfg_vec;
  cell_ctl_t        ctl;
  logic             lut_y;
  logic             q_sel;

  cell_rst_sync u_rst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_n_q)
  );

  cell_cfg_shift #(.W(CFG_W)) u_cfg (
    .clk_i (clk_i),
    .rst_ni(rst_n_q),
    .en_i  (cfg_en_i),
    .bit_i (cfg_bit_i),
    .vec_o (cfg_vec)
  );

  assign ctl = cell_ctl_t'(cfg_vec[CFG_W-1:TBL_W]);

  cell_lut #(.K(K)) u_lut (
    .tbl_i(cfg_vec[TBL_W-1:0]),
    .idx_i(din_i),
    .y_o  (lut_y)
  );

  cell_store u_ff (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_q),
    .hold_i   (cfg_en_i),
    .d_i      (lut_y),
    .ce_i     (ce_i),
    .sr_i     (sr_i),
    .async_m_i(ctl.async_m),
    .rval_i   (ctl.rval),
    .inv_i    (ctl.inv),
    .q_o      (q_sel)
  );

  always_comb begin
    cell_o = 1'b0;
    if (!cfg_en_i) cell_o = ctl.reg_out ? q_sel : lut_y;
  end
endmodule

// File: rtl/cell_chk.sv
module cell_chk #(
  parameter int K = 4
) (
  input logic                   clk_i,
  input logic                   rst_n,
  input logic                   cfg_en_i,
  input logic                   cfg_bit_i,
  input logic [K-1:0]           din_i,
  input logic                   ce_i,
  input logic                   sr_i,
  input logic                   cell_o,
  input logic [(1<<K)+3:0]      cfg_vec,
  input logic                   q_sel
);
  localparam int TBL_W = 1 << K;
  localparam int CFG_W = TBL_W + 4;

  logic inv, amode, rv;
  assign inv   = cfg_vec[TBL_W];
  assign amode = cfg_vec[TBL_W+1];
  assign rv    = cfg_vec[TBL_W+2];

  // R4
  load_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    cfg_en_i |-> (cell_o == 1'b0));

  // R3
  shift_in_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    cfg_en_i |=> (cfg_vec == {$past(cfg_bit_i), $past(cfg_vec[CFG_W-1:1])}));

  // R5
  capture_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!cfg_en_i && !inv && !amode && !sr_i && ce_i) |=> (q_sel == $past(cfg_vec[din_i])));

  // R6
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!cfg_en_i && !inv && !amode && !sr_i && !ce_i) |=> (q_sel == $past(q_sel)));

  // R7
  sync_set_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!cfg_en_i && !inv && !amode && sr_i) |=> (q_sel == $past(rv)));

  // R8
  async_set_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!cfg_en_i && amode && sr_i) |-> (q_sel == rv));
endmodule

bind cfg_logic_cell cell_chk #(.K(K)) u_chk (
  .clk_i    (clk_i),
  .rst_n    (rst_n_q),
  .cfg_en_i (cfg_en_i),
  .cfg_bit_i(cfg_bit_i),
  .din_i    (din_i),
  .ce_i     (ce_i),
  .sr_i     (sr_i),
  .cell_o   (cell_o),
  .cfg_vec  (cfg_vec),
  .q_sel    (q_sel)
);

// File: tb/tb_cfg_logic_cell.sv
`timescale 1ns/1ps
module tb_cfg_logic_cell;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cfg_en = 1'b0, cfg_bit = 1'b0;
  logic [3:0] din = 4'd0;
  logic       ce = 1'b0, sr = 1'b0;
  logic       cell_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  typedef struct { logic exp; string tag; } item_t;
  item_t sb_q[$];

  always #4 clk = ~clk;

  cfg_logic_cell dut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_en_i(cfg_en), .cfg_bit_i(cfg_bit),
    .din_i(din), .ce_i(ce), .sr_i(sr), .cell_o(cell_o)
  );

  // Config vector: {out_sel, set_val, async_mode, clk_inv, table[15:0]}
  function automatic logic [19:0] mk(input logic [15:0] t, input logic iv,
                                     input logic am, input logic rv, input logic os);
    return {os, rv, am, iv, t};
  endfunction

  // Expected value is compared at +2 ns after the rising edge of the current cycle
  task automatic push(input logic e, input string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic cyc(input logic [3:0] d, input logic c, input logic s);
    @(posedge clk); #1;
    din = d; ce = c; sr = s;
  endtask

  task automatic load(input logic [19:0] v);
    @(posedge clk); #1;
    cfg_en = 1'b1; cfg_bit = v[0];
    push(1'b0, "R4");
    for (int i = 1; i < 20; i++) begin
      @(posedge clk); #1;
      cfg_bit = v[i];
      push(1'b0, "R4");
    end
    @(posedge clk); #1;
    cfg_en = 1'b0; sr = 1'b0; ce = 1'b0;
  endtask

  // Monitor
  initial begin
    forever begin
      @(posedge clk); #2;
      while (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        checks++;
        if (cell_o !== it.exp) begin
          errors++;
          $display("FAIL %s actual=%0b expected=%0b at %0t", it.tag, cell_o, it.exp, $time);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] t2;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    repeat (3) @(posedge clk);

    // R1: cleared configuration, output 0
    cyc(4'd0, 1'b0, 1'b0); push(1'b0, "R1");
    cyc(4'd15, 1'b0, 1'b0); push(1'b0, "R1");

    // R2: parity table, index order din[0] = LSB
    load(mk(16'h6996, 1'b0, 1'b0, 1'b0, 1'b0));
    for (int k = 0; k < 16; k++) begin
      cyc(4'(k), 1'b0, 1'b0); push(^4'(k), "R2");
    end

    // R3: asymmetric table exposes shift order
    t2 = 16'h1F2E;
    load(mk(t2, 1'b0, 1'b0, 1'b0, 1'b0));
    for (int k = 0; k < 16; k++) begin
      cyc(4'(k), 1'b0, 1'b0); push(t2[k], "R3");
    end

    // Registered, rising edge, synchronous set/reset to 1, table = AND
    load(mk(16'h8000, 1'b0, 1'b0, 1'b1, 1'b1));
    cyc(4'd0, 1'b0, 1'b1); push(1'b0, "R7");      // not before the edge
    cyc(4'd0, 1'b0, 1'b0); push(1'b1, "R7");
    cyc(4'd0, 1'b1, 1'b0); push(1'b1, "R5");
    cyc(4'd15, 1'b1, 1'b0); push(1'b0, "R5");     // captured din=0
    cyc(4'd0, 1'b0, 1'b0); push(1'b1, "R5");      // captured din=15
    cyc(4'd0, 1'b0, 1'b0); push(1'b1, "R6");
    cyc(4'd0, 1'b1, 1'b0); push(1'b1, "R6");
    cyc(4'd0, 1'b0, 1'b0); push(1'b0, "R5");
    cyc(4'd15, 1'b1, 1'b0); push(1'b0, "R5");
    cyc(4'd0, 1'b1, 1'b1); push(1'b1, "R5");
    cyc(4'd0, 1'b0, 1'b0); push(1'b1, "R9");      // sr won over ce with d=0

    // R4: ce/sr active during loading must not disturb the flip-flop (q=1)
    cyc(4'd0, 1'b1, 1'b1);
    load(mk(16'h8000, 1'b0, 1'b1, 1'b0, 1'b1));   // async, set value 0
    cyc(4'd0, 1'b0, 1'b0); push(1'b1, "R4");

    // R8: asynchronous set/reset acts within the cycle
    cyc(4'd0, 1'b0, 1'b1); push(1'b0, "R8");
    cyc(4'd15, 1'b1, 1'b1); push(1'b0, "R9");
    cyc(4'd15, 1'b1, 1'b1); push(1'b0, "R9");
    cyc(4'd15, 1'b1, 1'b0); push(1'b0, "R5");
    cyc(4'd0, 1'b0, 1'b0); push(1'b1, "R5");

    // R10: falling-edge sampling, synchronous set value 0
    load(mk(16'h8000, 1'b1, 1'b0, 1'b0, 1'b1));
    cyc(4'd0, 1'b0, 1'b1);
    cyc(4'd0, 1'b0, 1'b0); push(1'b0, "R7");
    cyc(4'd15, 1'b1, 1'b0);
    #5 din = 4'd0;                                // after falling edge, before rising edge
    cyc(4'd0, 1'b0, 1'b0); push(1'b1, "R10");
    cyc(4'd0, 1'b0, 1'b0); push(1'b1, "R6");
    cyc(4'd0, 1'b0, 1'b1); push(1'b1, "R7");      // falling edge not yet reached
    cyc(4'd0, 1'b0, 1'b0); push(1'b0, "R10");

    repeat (2) @(posedge clk);
    #3;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule